// File: doc/BRIEF.md
# Embedded Audio Lock Detector

This block decides whether audio carried inside a digital video stream is synchronous with that video, and only then lets audio extraction begin. It watches frame strobes, audio sample strobes and the identifiers of detected ancillary packets. It then raises a lock output, a matching status bit and a demultiplex enable. A mode bit chooses one of two ways to reach lock.

In counting mode the block counts audio samples over a window of one or more frames. It locks when the total equals a configured value, for example 1920 samples over one frame or 8008 samples over five frames at 48 kHz. In packet mode it locks on an audio control packet. That packet must carry the selected identifier and arrive at a configured line and word position.

Once locked, the indication does not care how many samples a frame holds. It drops only after a configurable number of consecutive frames with no activity. Activity means any sample in counting mode and a qualifying control packet in packet mode. Dropping lock restarts acquisition. A change of mode or of video standard also returns the block to the unlocked state.

Top module: `audio_lock_detector`

## Requirements
- R1: After reset, `lock_o`, `lock_stat` and `demux_en` are low.
- R2: In counting mode (`use_pkt` = 0), the first `frame_stb` arms a window of `frame_span` frames (0 is treated as 1). Samples are counted from the arming strobe cycle onward. At the strobe that closes the window, if the count equals `exp_count`, lock is high from the cycle after that strobe.
- R3: In counting mode, a window whose count differs from `exp_count` gives no lock. The closing strobe starts a new window at once.
- R4: In packet mode (`use_pkt` = 1), a `pkt_stb` qualifies when three things hold: `pkt_id[7:4]` equals the fixed upper nibble 4'hE, `pkt_id[3:0]` equals `ctl_sel`, and `line_num`/`word_pos` equal `exp_line`/`exp_pos`. A qualifying packet makes lock high from the next cycle.
- R5: In packet mode, a packet that fails any part of the R4 match gives no lock, and neither do audio samples.
- R6: `lock_o`, `lock_stat` and `demux_en` always carry the same value.
- R7: While locked, lock stays high whatever the per-frame sample count, as long as every frame holds some activity.
- R8: While locked, activity is any `sample_stb` in counting mode and a qualifying packet in packet mode. After `miss_limit` consecutive frames without activity (0 treated as 1), lock falls from the cycle after the `frame_stb` that closes the last empty frame. Samples are not activity in packet mode.
- R9: Losing lock clears the acquisition state. The strobe that drops lock does not arm a window, so counting restarts at the next `frame_stb`.
- R10: A change of `use_pkt` or `std_sel` forces lock low from the cycle after the change and restarts acquisition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| use_pkt | input | 1 | Criterion select: 0 sample counting, 1 control packet |
| std_sel | input | 3 | Selected video standard; a change restarts acquisition |
| frame_stb | input | 1 | One-cycle pulse at the start of each frame |
| sample_stb | input | 1 | One-cycle pulse per audio sample found |
| line_num | input | LINE_W | Current line number |
| word_pos | input | POS_W | Current word position in the line |
| pkt_stb | input | 1 | Ancillary packet detected this cycle |
| pkt_id | input | ID_W | Identifier of the detected packet |
| ctl_sel | input | 4 | Low nibble of the expected control packet identifier |
| exp_line | input | LINE_W | Line where the control packet must appear |
| exp_pos | input | POS_W | Word position where the control packet must appear |
| exp_count | input | CNT_W | Samples expected per counting window |
| frame_span | input | SPAN_W | Frames per counting window |
| miss_limit | input | MISS_W | Empty frames tolerated before lock is dropped |
| lock_o | output | 1 | Lock indication |
| lock_stat | output | 1 | Lock status bit, same value as lock_o |
| demux_en | output | 1 | Audio extraction enable, same value as lock_o |

## Verification
The embedded assertions check four rules on every cycle. Lock rises only in the cycle after an acquisition event from the selected criterion. Lock falls only after a loss pulse or a configuration change. A configuration change always leaves the block unlocked. A counting window arms only on a frame strobe. Three behaviours need the bench's frame-by-frame scenarios: that the sample total and the packet line, position and identifier all decide lock, that lock survives changing sample counts, and that the exact frame on which lock falls after empty frames is right. The bench also shows that samples are ignored in packet mode and that acquisition restarts cleanly after loss.

// File: rtl/alk_pkg.sv
package alk_pkg;
   typedef enum logic {
      CRIT_COUNT = 1'b0,
      CRIT_PKT   = 1'b1
   } crit_e;

   localparam int SEL_W = 4;
endpackage

// File: rtl/alk_win_counter.sv
module alk_win_counter #(
   parameter int CNT_W    = 14,
   parameter int SPAN_W   = 3,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              frame_stb,
   input  logic              sample_stb,
   input  logic [SPAN_W-1:0] span,
   input  logic [CNT_W-1:0]  exp_cnt,
   output logic              done_o,
   output logic              match_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic              armed_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  cnt_inc;
   logic [SPAN_W-1:0] fcnt_q;
   logic [SPAN_W-1:0] span_m1;

   if (CNT_W < 2)  begin : g_bad_cnt  $error("CNT_W too small");  end
   if (SPAN_W < 1) begin : g_bad_span $error("SPAN_W too small"); end

   assign span_m1 = (span == '0) ? '0 : span - 1'b1;

   generate
      if (SATURATE) begin : g_sat
         assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
      end else begin : g_wrap
         assign cnt_inc = cnt_q + 1'b1;
      end
   endgenerate

   assign done_o  = armed_q & frame_stb & (fcnt_q >= span_m1);
   assign match_o = done_o & (cnt_q == exp_cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
         fcnt_q  <= '0;
      end else if (clr) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
         fcnt_q  <= '0;
      end else if (frame_stb) begin
         if (!armed_q || done_o) begin
            armed_q <= 1'b1;
            cnt_q   <= {{(CNT_W-1){1'b0}}, sample_stb};
            fcnt_q  <= '0;
         end else begin
            fcnt_q <= fcnt_q + 1'b1;
            if (sample_stb) cnt_q <= cnt_inc;
         end
      end else if (armed_q && sample_stb) begin
         cnt_q <= cnt_inc;
      end
   end

   // R2
   arm_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed_q) |-> $past(frame_stb));
endmodule

// File: rtl/alk_pkt_qual.sv
module alk_pkt_qual #(
   parameter int           ID_W     = 8,
   parameter int           LINE_W   = 11,
   parameter int           POS_W    = 12,
   parameter logic [3:0]   CTL_BASE = 4'hE,
   parameter bit           REG_OUT  = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     pkt_stb,
   input  logic [ID_W-1:0]          pkt_id,
   input  logic [alk_pkg::SEL_W-1:0] ctl_sel,
   input  logic [LINE_W-1:0]        line_num,
   input  logic [POS_W-1:0]         word_pos,
   input  logic [LINE_W-1:0]        exp_line,
   input  logic [POS_W-1:0]         exp_pos,
   output logic                     hit_o
);
   localparam int SEL_W = alk_pkg::SEL_W;
   localparam int HI_W  = ID_W - SEL_W;

   if (ID_W <= SEL_W) begin : g_bad_id $error("ID_W must exceed SEL_W"); end

   logic id_ok;
   logic where_ok;
   logic hit_raw;

   assign id_ok    = (pkt_id[SEL_W-1:0] == ctl_sel) &&
                     (pkt_id[ID_W-1:SEL_W] == HI_W'(CTL_BASE));
   assign where_ok = (line_num == exp_line) && (word_pos == exp_pos);
   assign hit_raw  = pkt_stb & id_ok & where_ok;

   generate
      if (REG_OUT) begin : g_reg
         logic hit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hit_q <= 1'b0;
            else        hit_q <= hit_raw;
         end
         assign hit_o = hit_q;
      end else begin : g_comb
         assign hit_o = hit_raw;
      end
   endgenerate
endmodule

// File: rtl/alk_loss_watch.sv
module alk_loss_watch #(
   parameter int MISS_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              locked,
   input  logic              frame_stb,
   input  logic              act,
   input  logic [MISS_W-1:0] limit,
   output logic              lose_o
);
   localparam logic [MISS_W-1:0] MISS_MAX = '1;

   if (MISS_W < 1) begin : g_bad_miss $error("MISS_W too small"); end

   logic              seen_q;
   logic [MISS_W-1:0] miss_q;
   logic [MISS_W:0]   lim_eff;
   logic [MISS_W:0]   miss_next;
   logic              frame_busy;

   assign lim_eff    = (limit == '0) ? (MISS_W+1)'(1) : {1'b0, limit};
   assign miss_next  = {1'b0, miss_q} + 1'b1;
   assign frame_busy = seen_q | act;
   assign lose_o     = locked & frame_stb & ~frame_busy & (miss_next >= lim_eff);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= 1'b0;
         miss_q <= '0;
      end else if (!locked) begin
         seen_q <= 1'b0;
         miss_q <= '0;
      end else if (frame_stb) begin
         seen_q <= 1'b0;
         if (frame_busy)              miss_q <= '0;
         else if (miss_q != MISS_MAX) miss_q <= miss_q + 1'b1;
      end else if (act) begin
         seen_q <= 1'b1;
      end
   end

   // R8
   lose_at_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lose_o |-> (frame_stb && locked && !act));
endmodule

// File: rtl/audio_lock_detector.sv
module audio_lock_detector #(
   parameter int         ID_W      = 8,
   parameter int         LINE_W    = 11,
   parameter int         POS_W     = 12,
   parameter int         CNT_W     = 14,
   parameter int         SPAN_W    = 3,
   parameter int         MISS_W    = 4,
   parameter int         STD_W     = 3,
   parameter logic [3:0] CTL_BASE  = 4'hE,
   parameter bit         REG_PKT   = 1'b0,
   parameter bit         SATURATE  = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      use_pkt,
   input  logic [STD_W-1:0]          std_sel,
   input  logic                      frame_stb,
   input  logic                      sample_stb,
   input  logic [LINE_W-1:0]         line_num,
   input  logic [POS_W-1:0]          word_pos,
   input  logic                      pkt_stb,
   input  logic [ID_W-1:0]           pkt_id,
   input  logic [alk_pkg::SEL_W-1:0] ctl_sel,
   input  logic [LINE_W-1:0]         exp_line,
   input  logic [POS_W-1:0]          exp_pos,
   input  logic [CNT_W-1:0]          exp_count,
   input  logic [SPAN_W-1:0]         frame_span,
   input  logic [MISS_W-1:0]         miss_limit,
   output logic                      lock_o,
   output logic                      lock_stat,
   output logic                      demux_en
);
   import alk_pkg::*;

   if (STD_W < 1) begin : g_bad_std $error("STD_W too small"); end

   crit_e            crit;
   logic             lock_q;
   logic             win_done;
   logic             win_match;
   logic             pkt_hit;
   logic             lose;
   logic             acq;
   logic             act;
   logic             restart;
   logic             cfg_change;
   logic             prev_vld_q;
   logic             prev_mode_q;
   logic [STD_W-1:0] prev_std_q;
   logic             win_clr;

   assign crit = use_pkt ? CRIT_PKT : CRIT_COUNT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_vld_q  <= 1'b0;
         prev_mode_q <= 1'b0;
         prev_std_q  <= '0;
      end else begin
         prev_vld_q  <= 1'b1;
         prev_mode_q <= use_pkt;
         prev_std_q  <= std_sel;
      end
   end

   assign cfg_change = prev_vld_q & ((prev_mode_q != use_pkt) || (prev_std_q != std_sel));

   alk_win_counter #(
      .CNT_W   (CNT_W),
      .SPAN_W  (SPAN_W),
      .SATURATE(SATURATE)
   ) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (win_clr),
      .frame_stb (frame_stb),
      .sample_stb(sample_stb),
      .span      (frame_span),
      .exp_cnt   (exp_count),
      .done_o    (win_done),
      .match_o   (win_match)
   );

   alk_pkt_qual #(
      .ID_W    (ID_W),
      .LINE_W  (LINE_W),
      .POS_W   (POS_W),
      .CTL_BASE(CTL_BASE),
      .REG_OUT (REG_PKT)
   ) u_qual (
      .clk     (clk),
      .rst_n   (rst_n),
      .pkt_stb (pkt_stb),
      .pkt_id  (pkt_id),
      .ctl_sel (ctl_sel),
      .line_num(line_num),
      .word_pos(word_pos),
      .exp_line(exp_line),
      .exp_pos (exp_pos),
      .hit_o   (pkt_hit)
   );

   alk_loss_watch #(
      .MISS_W(MISS_W)
   ) u_loss (
      .clk      (clk),
      .rst_n    (rst_n),
      .locked   (lock_q),
      .frame_stb(frame_stb),
      .act      (act),
      .limit    (miss_limit),
      .lose_o   (lose)
   );

   assign acq     = (crit == CRIT_PKT) ? pkt_hit : win_match;
   assign act     = (crit == CRIT_PKT) ? pkt_hit : sample_stb;
   assign restart = cfg_change | lose;
   assign win_clr = restart | lock_q | (crit == CRIT_PKT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                lock_q <= 1'b0;
      else if (restart)          lock_q <= 1'b0;
      else if (!lock_q && acq)   lock_q <= 1'b1;
   end

   assign lock_o    = lock_q;
   assign lock_stat = lock_q;
   assign demux_en  = lock_q;

   // R2
   lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_q) |-> $past(acq && !restart));

   // R8
   lock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lock_q) |-> $past(restart));

   // R10
   cfg_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_change |=> !lock_q);
endmodule

// File: tb/tb_audio_lock_detector.sv
module tb_audio_lock_detector;
   localparam int FL       = 8;
   localparam int WATCHDOG = 200000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        use_pkt = 1'b0;
   logic [2:0]  std_sel = 3'd1;
   logic        frame_stb = 1'b0;
   logic        sample_stb = 1'b0;
   logic [10:0] line_num = '0;
   logic [11:0] word_pos = '0;
   logic        pkt_stb = 1'b0;
   logic [7:0]  pkt_id = '0;
   logic [3:0]  ctl_sel = 4'h3;
   logic [10:0] exp_line = 11'd9;
   logic [11:0] exp_pos = 12'd1001;
   logic [13:0] exp_count = 14'd6;
   logic [2:0]  frame_span = 3'd2;
   logic [3:0]  miss_limit = 4'd2;
   logic        lock_o, lock_stat, demux_en;

   int    nchk = 0;
   int    nfail = 0;
   bit    exp_q[$];
   string tag_q[$];
   bit    done = 1'b0;

   always #2 clk = ~clk;

   audio_lock_detector dut (
      .clk(clk), .rst_n(rst_n), .use_pkt(use_pkt), .std_sel(std_sel),
      .frame_stb(frame_stb), .sample_stb(sample_stb), .line_num(line_num),
      .word_pos(word_pos), .pkt_stb(pkt_stb), .pkt_id(pkt_id), .ctl_sel(ctl_sel),
      .exp_line(exp_line), .exp_pos(exp_pos), .exp_count(exp_count),
      .frame_span(frame_span), .miss_limit(miss_limit),
      .lock_o(lock_o), .lock_stat(lock_stat), .demux_en(demux_en)
   );

   // monitor: pops one expectation per cycle and compares (R6: all three outputs)
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         bit    e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         nchk++;
         if (lock_o !== e || lock_stat !== e || demux_en !== e) begin
            nfail++;
            $display("FAIL %s: lock_o=%b lock_stat=%b demux_en=%b expected %b",
                     t, lock_o, lock_stat, demux_en, e);
         end
      end
   end

   task automatic push(input bit e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
   endtask

   task automatic clear_in();
      frame_stb  = 1'b0;
      sample_stb = 1'b0;
      pkt_stb    = 1'b0;
      pkt_id     = '0;
      line_num   = '0;
      word_pos   = '0;
   endtask

   // kind: 0 none, 1 good packet, 2 wrong id, 3 wrong line, 4 wrong position
   task automatic frame(input int ns, input int kind, input bit exp_s,
                        input bit exp_p, input string t);
      for (int i = 0; i < FL; i++) begin
         @(negedge clk);
         clear_in();
         frame_stb  = (i == 0);
         sample_stb = (i >= 1 && i <= ns);
         if (i == 2 && kind != 0) begin
            pkt_stb  = 1'b1;
            pkt_id   = {(kind == 2) ? 4'hD : 4'hE, ctl_sel};
            line_num = (kind == 3) ? exp_line + 11'd1 : exp_line;
            word_pos = (kind == 4) ? exp_pos + 12'd1 : exp_pos;
         end
         @(posedge clk);
         #1;
         if (i == 0) push(exp_s, {t, " @strobe"});
         if (i == 2) push(exp_p, {t, " @packet"});
      end
   endtask

   task automatic idle_check(input bit e, input string t);
      @(negedge clk);
      clear_in();
      @(posedge clk);
      #1;
      push(e, t);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      clear_in();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      idle_check(1'b0, "R1 reset state");

      // counting mode: mismatch window then match
      frame(3, 0, 1'b0, 1'b0, "R2 arm window");
      frame(2, 0, 1'b0, 1'b0, "R3 second frame");
      frame(3, 0, 1'b0, 1'b0, "R3 count 5 != 6 no lock");
      frame(3, 0, 1'b0, 1'b0, "R3 new window mid");
      frame(3, 0, 1'b1, 1'b1, "R2 count 6 locks");
      frame(7, 0, 1'b1, 1'b1, "R7 hold varied count");
      frame(1, 0, 1'b1, 1'b1, "R7 hold another count");
      frame(0, 0, 1'b1, 1'b1, "R7 hold frame with samples");
      frame(0, 0, 1'b1, 1'b1, "R8 one empty frame kept");
      frame(4, 0, 1'b0, 1'b0, "R8 second empty frame drops");
      frame(3, 0, 1'b0, 1'b0, "R9 re-arm after loss");
      frame(3, 0, 1'b0, 1'b0, "R9 window mid");
      frame(0, 0, 1'b1, 1'b1, "R9 relock count 6");

      // standard change
      std_sel = 3'd2;
      idle_check(1'b0, "R10 standard change unlocks");

      // packet mode
      use_pkt = 1'b1;
      idle_check(1'b0, "R10 mode change unlocked");
      frame(5, 0, 1'b0, 1'b0, "R5 samples ignored in packet mode");
      frame(0, 2, 1'b0, 1'b0, "R5 wrong id");
      frame(0, 3, 1'b0, 1'b0, "R5 wrong line");
      frame(0, 4, 1'b0, 1'b0, "R5 wrong position");
      frame(0, 1, 1'b0, 1'b1, "R4 good packet locks");
      frame(0, 1, 1'b1, 1'b1, "R7 packet hold 1");
      frame(0, 1, 1'b1, 1'b1, "R7 packet hold 2");
      frame(0, 0, 1'b1, 1'b1, "R8 packet frame closed busy");
      frame(5, 0, 1'b1, 1'b1, "R8 first empty packet frame");
      frame(0, 0, 1'b0, 1'b0, "R8 samples not activity, drops");
      frame(0, 1, 1'b0, 1'b1, "R9 packet relock");

      use_pkt = 1'b0;
      idle_check(1'b0, "R10 mode change to counting unlocks");
      idle_check(1'b0, "R10 stays unlocked");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule